// File: doc/BRIEF.md
# Floppy Write Gate Sequencer

This block drives the write side of a floppy drive interface. An upstream source supplies an already-encoded MFM bit stream, one bit at a time, over a ready/valid handshake. The block lowers the active-low write gate and places each bit in a fixed bit cell. A 1 bit produces a short write pulse at the start of its cell. A 0 bit leaves the cell empty.

The block also enforces the drive's timing rules. It waits out the settle time after a head step and after a drive select before it lowers the gate. It bounds the lead time from the gate falling to the first cell. It releases the gate shortly after the final cell ends. When the track written is the last one, it holds busy for an extra period before it returns to idle. If the source runs dry in the middle of a write, the block ends the write at once and raises a sticky underrun flag.

The sequence runs through idle, settle, gate-on, shift, gate-off, an optional hold, and back to idle.

Top module: `fwg_seq`

## Requirements
- R1: After reset, the write gate is high (inactive), the write pulse is low, and busy, bit-ready and underrun are all low.
- R2: The write gate is low only while writing. The first bit cell begins LEAD_US after the gate falls, and the first pulse follows one clock later. When no settle timer is running, the gate falls two clocks after start_i is sampled in idle.
- R3: Each 1 bit produces one pulse of exactly CYC_PER_US/2 clocks (0.5 us) at the start of its cell. A 0 bit produces no pulse. Pulses in consecutive cells are spaced BIT_US*CYC_PER_US clocks apart. bit_i=1 means a pulse.
- R4: The block consumes exactly one bit per cell. bit_ready_o is high for one clock at the start of each cell, and a bit is taken only when bit_valid_i is also high.
- R5: A bit presented with bit_last_i high is the final bit. The gate rises the clock after that bit's cell ends, and busy falls TAIL_US later (within 8 us of the last pulse).
- R6: The gate never falls until STEP_SETTLE_US has passed since the most recent step_i pulse. A new step during the settle wait restarts the wait.
- R7: The gate never falls until SEL_SETTLE_US has passed since the most recent sel_i pulse.
- R8: When last_trk_i is high at the accepted start, busy stays high for an extra HOLD_US after the tail period.
- R9: If bit_valid_i is low at the start of a cell, the gate rises on the next clock and underrun_o goes high. underrun_o stays high until the next start is accepted.
- R10: start_i has no effect while busy. After a write that saw a start request mid-way, the block returns to idle on schedule and stays there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | One-clock event: head step issued |
| sel_i | input | 1 | One-clock event: drive selected |
| start_i | input | 1 | Request to write a track |
| last_trk_i | input | 1 | Start qualifier: this is the final track |
| bit_i | input | 1 | MFM bit (1 = pulse) |
| bit_last_i | input | 1 | Marks the final bit of the track |
| bit_valid_i | input | 1 | Bit stream valid |
| bit_ready_o | output | 1 | Bit taken this clock if valid |
| wgate_n_o | output | 1 | Write gate, active low |
| wpulse_o | output | 1 | Write data pulse, active high |
| busy_o | output | 1 | Write sequence in progress |
| underrun_o | output | 1 | Source ran dry during the last write |

## Verification
The bench builds the block with CYC_PER_US=4, STEP_SETTLE_US=30, SEL_SETTLE_US=10 and HOLD_US=20. These values make the bit cell 8 clocks and the pulse 2 clocks. They also shrink the 18 ms step settle to 120 clocks, so retriggered settles, the end-of-track hold and exact pulse placement can all be checked cycle by cycle in a short run. With the same ratios, the default parameters give the real 2 us cell, 18 ms step settle, 100 us select settle and 650 us hold.

// File: rtl/fwg_seq.sv
`timescale 1ns/1ps
module fwg_seq #(
  parameter int CYC_PER_US     = 100,
  parameter int BIT_US         = 2,
  parameter int LEAD_US        = 4,
  parameter int TAIL_US        = 2,
  parameter int STEP_SETTLE_US = 18000,
  parameter int SEL_SETTLE_US  = 100,
  parameter int HOLD_US        = 650
)(
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic sel_i,
  input  logic start_i,
  input  logic last_trk_i,
  input  logic bit_i,
  input  logic bit_last_i,
  input  logic bit_valid_i,
  output logic bit_ready_o,
  output logic wgate_n_o,
  output logic wpulse_o,
  output logic busy_o,
  output logic underrun_o
);
  localparam int BIT_CYC   = BIT_US * CYC_PER_US;
  localparam int PULSE_CYC = CYC_PER_US / 2;
  localparam int LEAD_CYC  = LEAD_US * CYC_PER_US;
  localparam int TAIL_CYC  = TAIL_US * CYC_PER_US;
  localparam int HOLD_CYC  = HOLD_US * CYC_PER_US;
  localparam int STEP_CYC  = STEP_SETTLE_US * CYC_PER_US;
  localparam int SEL_CYC   = SEL_SETTLE_US * CYC_PER_US;
  localparam int CW = $clog2(LEAD_CYC + BIT_CYC + TAIL_CYC + HOLD_CYC + 1);
  localparam int TW = $clog2(STEP_CYC + SEL_CYC + 1);

  typedef enum logic [2:0] {IDLE, SETTLE, GATE_ON, SHIFT, GATE_OFF, HOLD} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] step_tmr, sel_tmr;
  logic pulse_q, last_q, hold_q, urun_q;

  wire timers_clr = (step_tmr == '0) && (sel_tmr == '0);
  wire cell_start = (st == SHIFT) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_tmr <= '0;
      sel_tmr  <= '0;
    end else begin
      if (step_i) step_tmr <= TW'(STEP_CYC);
      else if (step_tmr != '0) step_tmr <= step_tmr - 1'b1;
      if (sel_i) sel_tmr <= TW'(SEL_CYC);
      else if (sel_tmr != '0) sel_tmr <= sel_tmr - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      pulse_q <= 1'b0;
      last_q  <= 1'b0;
      hold_q  <= 1'b0;
      urun_q  <= 1'b0;
    end else begin
      case (st)
        IDLE: if (start_i) begin
          st     <= SETTLE;
          hold_q <= last_trk_i;
          urun_q <= 1'b0;
          last_q <= 1'b0;
        end
        SETTLE: if (timers_clr) begin
          st  <= GATE_ON;
          cnt <= '0;
        end
        GATE_ON: begin
          if (cnt == CW'(LEAD_CYC - 1)) begin
            st  <= SHIFT;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        SHIFT: begin
          if (cnt == '0) begin
            if (bit_valid_i) begin
              pulse_q <= bit_i;
              last_q  <= bit_last_i;
              cnt     <= CW'(1);
            end else begin
              st     <= GATE_OFF;
              urun_q <= 1'b1;
            end
          end else begin
            if (cnt == CW'(PULSE_CYC)) pulse_q <= 1'b0;
            if (cnt == CW'(BIT_CYC - 1)) begin
              cnt <= '0;
              if (last_q) st <= GATE_OFF;
            end else cnt <= cnt + 1'b1;
          end
        end
        GATE_OFF: begin
          if (cnt == CW'(TAIL_CYC - 1)) begin
            cnt <= '0;
            st  <= hold_q ? HOLD : IDLE;
          end else cnt <= cnt + 1'b1;
        end
        HOLD: begin
          if (cnt == CW'(HOLD_CYC - 1)) begin
            cnt <= '0;
            st  <= IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign bit_ready_o = cell_start;
  assign wgate_n_o   = !((st == GATE_ON) || (st == SHIFT));
  assign wpulse_o    = pulse_q;
  assign busy_o      = (st != IDLE);
  assign underrun_o  = urun_q;
endmodule

// File: rtl/fwg_seq_chk.sv
`timescale 1ns/1ps
module fwg_seq_chk #(
  parameter int CYC_PER_US = 100
)(
  input logic clk,
  input logic rst_n,
  input logic gate_n,
  input logic pulse,
  input logic ready,
  input logic busy,
  input logic urun,
  input logic settled
);
  localparam int PULSE_CYC = CYC_PER_US / 2;
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else run <= pulse ? run + 16'd1 : 16'd0;
  end

  p_pulse_in_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> !gate_n);
  p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> run < 16'(PULSE_CYC));
  p_pulse_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse && run != 16'd0) |-> run == 16'(PULSE_CYC));
  p_ready_in_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !gate_n);
  p_busy_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_n |-> busy);
  // covers R6 and R7: both settle timers expired before the gate falls
  p_fall_settled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_n) |-> $past(settled));
  p_underrun_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(urun) |-> $rose(gate_n));
endmodule

bind fwg_seq fwg_seq_chk #(.CYC_PER_US(CYC_PER_US)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_n(wgate_n_o), .pulse(wpulse_o),
  .ready(bit_ready_o), .busy(busy_o), .urun(underrun_o), .settled(timers_clr)
);

// File: tb/fwg_seq_test.sv
`timescale 1ns/1ps
module fwg_seq_test;
  localparam int CPU = 4, STEP_US = 30, SEL_US = 10, HLD_US = 20;
  localparam int BIT = 2*CPU, PW = CPU/2, LEAD = 4*CPU, TAIL = 2*CPU;
  localparam int STEPC = STEP_US*CPU, SELC = SEL_US*CPU, HOLDC = HLD_US*CPU;

  logic clk = 0, rst_n = 0;
  logic step_i = 0, sel_i = 0, start_i = 0, last_trk_i = 0;
  logic bit_i = 0, bit_last_i = 0, bit_valid_i = 0;
  logic bit_ready_o, wgate_n_o, wpulse_o, busy_o, underrun_o;

  fwg_seq #(.CYC_PER_US(CPU), .STEP_SETTLE_US(STEP_US), .SEL_SETTLE_US(SEL_US),
            .HOLD_US(HLD_US)) uut (.*);

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bit source
  logic [31:0] pat = '0;
  int plen = 0, supply = 0, idx = 0;
  bit feed_on = 0, took = 0;
  always @(negedge clk) begin
    if (!feed_on) idx = 0;
    else if (took) idx = idx + 1;
    bit_valid_i = feed_on && (idx < supply);
    bit_i = (idx < 32) ? pat[idx] : 1'b0;
    bit_last_i = (idx == plen - 1);
    took = bit_ready_o && bit_valid_i;
  end

  // output monitor
  int p_t[256], p_w[256];
  int np = 0, cw = 0, t_fall = 0, t_rise = 0, t_idle = 0;
  bit pg = 1, pp = 0, pb = 0;
  always @(negedge clk) begin
    if (pg && !wgate_n_o) t_fall = cyc;
    if (!pg && wgate_n_o) t_rise = cyc;
    if (pb && !busy_o) t_idle = cyc;
    if (wpulse_o && !pp) begin
      if (np < 256) p_t[np] = cyc;
      np++;
      cw = 0;
    end
    if (wpulse_o) cw++;
    if (!wpulse_o && pp && np > 0 && np <= 256) p_w[np-1] = cw;
    pg = wgate_n_o; pp = wpulse_o; pb = busy_o;
  end

  task automatic run_write(input logic [31:0] p, input int n, input int sup, input bit lt,
                           input bit pre_step, input bit pre_sel,
                           input int restep_at, input int restart_at);
    int d, cs, cl, ef, k, m, base, j;
    bit und;
    string ftag;
    cs = -100000; cl = -100000;
    und = sup < n;
    m = und ? sup : n;
    ftag = pre_step ? "R6" : (pre_sel ? "R7" : "R2");
    @(negedge clk);
    pat = p; plen = n; supply = sup; feed_on = 1;
    if (pre_step) begin step_i = 1; cs = cyc; @(negedge clk); step_i = 0; end
    if (pre_sel) begin sel_i = 1; cl = cyc; @(negedge clk); sel_i = 0; end
    last_trk_i = lt; start_i = 1; d = cyc; base = np;
    @(negedge clk);
    start_i = 0;
    k = 1;
    while (busy_o && k < 20000) begin
      if (k == restep_at) begin step_i = 1; cs = cyc; end else step_i = 0;
      start_i = (k == restart_at);
      @(negedge clk);
      k++;
    end
    step_i = 0; start_i = 0; feed_on = 0;
    @(negedge clk);
    ef = d + 2;
    if (cs + STEPC + 2 > ef) ef = cs + STEPC + 2;
    if (cl + SELC + 2 > ef) ef = cl + SELC + 2;
    check({ftag, " gate fall time"}, t_fall, ef);
    j = 0;
    for (int b = 0; b < m; b++) begin
      if (p[b]) begin
        if (base + j < 256) begin
          check("R3 pulse position", p_t[base+j], t_fall + LEAD + 1 + b*BIT);
          check("R3 pulse width", p_w[base+j], PW);
        end
        j++;
      end
    end
    check("R4 pulse count", np - base, j);
    check(und ? "R9 gate release" : "R5 gate release", t_rise,
          t_fall + LEAD + m*BIT + (und ? 1 : 0));
    check(lt ? "R8 idle time" : "R5 idle time", t_idle, t_rise + TAIL + (lt ? HOLDC : 0));
    check("R9 underrun flag", int'(underrun_o), int'(und));
    if (restart_at > 0) begin
      repeat (3) @(negedge clk);
      check("R10 stays idle", int'(busy_o), 0);
      check("R10 gate stays high", int'(wgate_n_o), 1);
    end
  endtask

  task automatic t_reset;
    check("R1 gate", int'(wgate_n_o), 1);
    check("R1 pulse", int'(wpulse_o), 0);
    check("R1 busy", int'(busy_o), 0);
    check("R1 ready", int'(bit_ready_o), 0);
    check("R1 underrun", int'(underrun_o), 0);
  endtask

  task automatic t_basic;      run_write(32'h0000_0A94, 12, 12, 0, 0, 0, -1, -1); endtask
  task automatic t_dense_last; run_write(32'h0000_AAAA, 16, 16, 1, 0, 0, -1, -1); endtask
  task automatic t_zero_lead;  run_write(32'h0000_0488, 12, 12, 0, 0, 0, -1, -1); endtask
  task automatic t_underrun;   run_write(32'h0000_0155, 10, 6, 0, 0, 0, -1, -1); endtask
  task automatic t_clear_urun; run_write(32'h0000_0009, 4, 4, 0, 0, 0, -1, -1); endtask
  task automatic t_step;       run_write(32'h0000_0005, 3, 3, 0, 1, 0, -1, -1); endtask
  task automatic t_restep;     run_write(32'h0000_0005, 3, 3, 0, 1, 0, 40, -1); endtask
  task automatic t_select;     run_write(32'h0000_0003, 3, 3, 0, 0, 1, -1, -1); endtask
  task automatic t_busy_start; run_write(32'h0000_0025, 8, 8, 0, 0, 0, -1, 30); endtask
  task automatic t_single;     run_write(32'h0000_0001, 1, 1, 1, 0, 0, -1, -1); endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_dense_last();
    t_zero_lead();
    t_underrun();
    t_clear_urun();
    t_step();
    t_restep();
    t_select();
    t_busy_start();
    t_single();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule